// File: doc/BRIEF.md
# Bus Master Request Loader

This block sits between user logic and an embedded bus master engine and collects one transaction request at a time. User logic presents three words in a fixed order on a shared data input: a command word, a read burst length and a start address. It qualifies each word with a single active-low load strobe. A small step counter, readable by user logic, shows which word the next strobe captures. When the address is taken, the request is complete. The block then raises an active-low full indication, issues a one-cycle start pulse to the engine and refuses further loads until the engine reports that the transaction has finished.

The engine is represented only by its completion and termination inputs. The write-side completion means all write data has left for the target. The read-side completion means all read data has arrived from the target, whether or not the user has consumed it yet. A target abort ends the request early and leaves a sticky abort flag. An asynchronous active-low clear empties the request registers and the step counter at once. It does not disturb the bus request hold logic, which stands in for the bus engine. A ready output shows when the loading interface may be used.

A separate busy input lets user logic hold the bus request asserted across several back-to-back transactions. Once taken, the hold lasts for at least a configurable minimum number of cycles. It ends when busy is released or when the target disconnects.

Top module: `mreq_frontend`

## Requirements
- R1: On each rising clock edge with `ld_en_n` low and the full indication inactive, `ld_data` is captured: the low `CMD_W` bits into `cmd_o` at step 0, the low `LEN_W` bits into `len_o` at step 1, and all `DATA_W` bits into `addr_o` at step 2.
- R2: `step_cnt_o` reads 0 while waiting for a command, 1 while waiting for a burst length and 2 while waiting for an address. It advances by one on each accepted strobe and returns to 0 after the address is captured. It holds its value when the strobe is high.
- R3: `req_full_n_o` goes low at the edge that captures the address. While it is low, a load strobe changes neither `step_cnt_o` nor `cmd_o`, `len_o` or `addr_o`.
- R4: `start_o` is high for exactly the one cycle that follows the edge that captured the address.
- R5: For a write request (bit 0 of the command equal to 0), `req_full_n_o` returns high at the edge where `wr_done` is high. `rd_done` has no effect on it.
- R6: For a read request (bit 0 of the command equal to 1), `req_full_n_o` returns high at the edge where `rd_done` is high. This holds whether or not the read data has been drained. `wr_done` has no effect on it.
- R7: A `tgt_abort` seen at an edge while a request is outstanding releases `req_full_n_o` and sets `abort_o`. `abort_o` stays high until the next `start_o` and is cleared at that edge. `tgt_abort` is ignored when no request is outstanding.
- R8: While `clr_n` is low, with or without a clock edge, `step_cnt_o` is 0, `cmd_o`, `len_o` and `addr_o` are 0, `req_full_n_o` is high and `abort_o` and `start_o` are low.
- R9: `ready_o` is low while `rst_n` is low and while `clr_n` is low. It goes high at the first rising edge at which both are high.
- R10: A low `busy_n` seen at an edge starts a hold. `bus_req_o` is high whenever a hold is active or a request is outstanding.
- R11: A hold lasts at least `MIN_HOLD` cycles and ends at the first edge after that with `busy_n` high. A `tgt_disc` at an edge ends it immediately. After a disconnect, a new hold starts only once `busy_n` has been seen high again.
- R12: After reset, `step_cnt_o` is 0, `req_full_n_o` is high, and `start_o`, `abort_o` and `bus_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n | input | 1 | Asynchronous active-low clear of the request path |
| ld_en_n | input | 1 | Active-low load strobe |
| ld_data | input | DATA_W | Word being loaded |
| busy_n | input | 1 | Active-low request-hold input |
| wr_done | input | 1 | Engine: all write data sent |
| rd_done | input | 1 | Engine: all read data received |
| tgt_abort | input | 1 | Engine: target aborted the cycle |
| tgt_disc | input | 1 | Engine: target disconnected |
| step_cnt_o | output | 4 | Loading step counter |
| req_full_n_o | output | 1 | Active-low request-outstanding flag |
| start_o | output | 1 | One-cycle start pulse to engine |
| cmd_o | output | CMD_W | Captured command |
| len_o | output | LEN_W | Captured read burst length |
| addr_o | output | DATA_W | Captured start address |
| abort_o | output | 1 | Sticky abort indication |
| ready_o | output | 1 | Loading interface ready |
| bus_req_o | output | 1 | Bus request to engine |

## Verification
The bench builds the block with a 16-bit data word, a 4-bit command, a 6-bit burst length and a three-cycle minimum hold. The narrow word keeps the address, burst-length and command fields distinct and easy to check against each other. A minimum hold of three, rather than two, separates a busy pulse released early from one released after the minimum. It also lets the bench check the hold cycle by cycle across the whole window.

// File: rtl/mreq_pkg.sv
// Package: shared encodings for the bus master request loader.
// Assumes: step codes fit the 4-bit counter exposed to user logic.
package mreq_pkg;
    localparam int STEP_W = 4;

    typedef enum logic [STEP_W-1:0] {
        STEP_CMD  = 4'd0,
        STEP_LEN  = 4'd1,
        STEP_ADDR = 4'd2
    } step_e;

    // command bit that marks a read transaction
    localparam int CMD_RD_BIT = 0;
endpackage

// File: rtl/mreq_loader.sv
// Module: request loader. It captures command, burst length and address in
// sequence under one active-low strobe, holds the full flag until the engine
// reports completion or abort, and raises the start pulse.
// Assumes: clr_n is asynchronous and has priority over the synchronous rst_n.
module mreq_loader
    import mreq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CMD_W  = 4,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              ld_en_n,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              wr_done,
    input  logic              rd_done,
    input  logic              tgt_abort,
    output logic [STEP_W-1:0] step_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [DATA_W-1:0] addr_o,
    output logic              full_o,
    output logic              start_o,
    output logic              abort_o
);
    step_e             step_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [LEN_W-1:0]  len_q;
    logic [DATA_W-1:0] addr_q;
    logic              full_q;
    logic              start_q;
    logic              abort_q;
    logic              is_read;
    logic              finish;
    logic              take;

    // decode the direction of the outstanding request and its end condition
    always_comb begin
        is_read = cmd_q[CMD_RD_BIT];
        finish  = tgt_abort || (is_read ? rd_done : wr_done);
        take    = !ld_en_n && !full_q;
    end

    // sequence the three words, track full/abort, pulse start
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            step_q  <= STEP_CMD;
            cmd_q   <= '0;
            len_q   <= '0;
            addr_q  <= '0;
            full_q  <= 1'b0;
            start_q <= 1'b0;
            abort_q <= 1'b0;
        end else if (!rst_n) begin
            step_q  <= STEP_CMD;
            cmd_q   <= '0;
            len_q   <= '0;
            addr_q  <= '0;
            full_q  <= 1'b0;
            start_q <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (full_q) begin
                if (finish) begin
                    full_q <= 1'b0;
                end
                if (tgt_abort) begin
                    abort_q <= 1'b1;
                end
            end else if (take) begin
                unique case (step_q)
                    STEP_CMD: begin
                        cmd_q  <= ld_data[CMD_W-1:0];
                        step_q <= STEP_LEN;
                    end
                    STEP_LEN: begin
                        len_q  <= ld_data[LEN_W-1:0];
                        step_q <= STEP_ADDR;
                    end
                    STEP_ADDR: begin
                        addr_q  <= ld_data;
                        step_q  <= STEP_CMD;
                        full_q  <= 1'b1;
                        start_q <= 1'b1;
                        abort_q <= 1'b0;
                    end
                    default: step_q <= STEP_CMD;
                endcase
            end
        end
    end

    // present registered state
    always_comb begin
        step_o  = step_q;
        cmd_o   = cmd_q;
        len_o   = len_q;
        addr_o  = addr_q;
        full_o  = full_q;
        start_o = start_q;
        abort_o = abort_q;
    end
endmodule

// File: rtl/mreq_hold.sv
// Module: bus request hold. A low busy input starts a hold that lasts at least
// MIN_HOLD cycles and ends on busy release or target disconnect. After a
// disconnect it re-arms only once busy has been seen high.
// Assumes: MIN_HOLD >= 2; clear does not touch this logic.
module mreq_hold #(
    parameter int MIN_HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_n,
    input  logic tgt_disc,
    output logic hold_o
);
    localparam int CNT_W = $clog2(MIN_HOLD + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_HOLD - 1);

    logic             hold_q;
    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;

    // hold state machine with minimum-length counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= 1'b0;
            armed_q <= 1'b1;
            cnt_q   <= '0;
        end else if (hold_q) begin
            if (tgt_disc) begin
                hold_q  <= 1'b0;
                armed_q <= 1'b0;
            end else if (busy_n && cnt_q >= CNT_LAST) begin
                hold_q <= 1'b0;
            end else if (cnt_q < CNT_LAST) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
            if (busy_n) begin
                armed_q <= 1'b1;
            end else if (armed_q) begin
                hold_q <= 1'b1;
            end
        end
    end

    assign hold_o = hold_q;
endmodule

// File: rtl/mreq_frontend.sv
// Module: bus master request front-end top. It joins the request loader, the
// busy hold and the ready flag, and forms the bus request.
// Assumes: LEN_W and CMD_W do not exceed DATA_W.
module mreq_frontend #(
    parameter int DATA_W   = 32,
    parameter int CMD_W    = 4,
    parameter int LEN_W    = 8,
    parameter int MIN_HOLD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              ld_en_n,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              busy_n,
    input  logic              wr_done,
    input  logic              rd_done,
    input  logic              tgt_abort,
    input  logic              tgt_disc,
    output logic [3:0]        step_cnt_o,
    output logic              req_full_n_o,
    output logic              start_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [DATA_W-1:0] addr_o,
    output logic              abort_o,
    output logic              ready_o,
    output logic              bus_req_o
);
    logic full_w;
    logic hold_w;
    logic ready_q;

    mreq_loader #(
        .DATA_W (DATA_W),
        .CMD_W  (CMD_W),
        .LEN_W  (LEN_W)
    ) loader_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_n     (clr_n),
        .ld_en_n   (ld_en_n),
        .ld_data   (ld_data),
        .wr_done   (wr_done),
        .rd_done   (rd_done),
        .tgt_abort (tgt_abort),
        .step_o    (step_cnt_o),
        .cmd_o     (cmd_o),
        .len_o     (len_o),
        .addr_o    (addr_o),
        .full_o    (full_w),
        .start_o   (start_o),
        .abort_o   (abort_o)
    );

    mreq_hold #(
        .MIN_HOLD (MIN_HOLD)
    ) hold_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy_n   (busy_n),
        .tgt_disc (tgt_disc),
        .hold_o   (hold_w)
    );

    // ready drops at once on clear, rises on the first edge out of reset and clear
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            ready_q <= 1'b0;
        end else begin
            ready_q <= rst_n;
        end
    end

    // drive the flag, ready and bus request outputs
    always_comb begin
        req_full_n_o = !full_w;
        ready_o      = ready_q;
        bus_req_o    = full_w || hold_w;
    end
endmodule

// File: rtl/mreq_frontend_chk.sv
// Module: property checker for the request front-end, bound to the top.
// Assumes: MIN_HOLD >= 2.
module mreq_frontend_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_n,
    input logic              ld_en_n,
    input logic [3:0]        step,
    input logic              full_n,
    input logic              start,
    input logic              abort,
    input logic              tgt_abort,
    input logic              wr_done,
    input logic              rd_done,
    input logic              tgt_disc,
    input logic              ready,
    input logic              hold,
    input logic [DATA_W-1:0] addr
);
    // R2: step counter stays within its three codes
    a_r2_step_range: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        step <= 4'd2);

    // R3: strobe while full leaves step and address unchanged
    a_r3_full_blocks: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (!full_n && !ld_en_n && !wr_done && !rd_done && !tgt_abort)
        |=> ($stable(step) && $stable(addr)));

    // R4: start lasts one cycle and comes with the full flag
    a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        start |=> !start);
    a_r4_start_full: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        start |-> !full_n);

    // R5/R6/R7: full releases only on a completion or abort
    a_r5_full_release: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        ($rose(full_n) && $past(clr_n)) |-> $past(wr_done || rd_done || tgt_abort));

    // R7: abort during an outstanding request sets the flag and frees the slot
    a_r7_abort_sets: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (tgt_abort && !full_n) |=> (abort && full_n));

    // R9: ready is low whenever clear is asserted
    a_r9_ready_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> !ready);

    // R11: a fresh hold survives at least one more edge unless disconnected
    a_r11_hold_min: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hold) && !tgt_disc) |=> hold);
endmodule

bind mreq_frontend mreq_frontend_chk #(
    .DATA_W (DATA_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n     (clr_n),
    .ld_en_n   (ld_en_n),
    .step      (step_cnt_o),
    .full_n    (req_full_n_o),
    .start     (start_o),
    .abort     (abort_o),
    .tgt_abort (tgt_abort),
    .wr_done   (wr_done),
    .rd_done   (rd_done),
    .tgt_disc  (tgt_disc),
    .ready     (ready_o),
    .hold      (hold_w),
    .addr      (addr_o)
);

// File: tb/mreq_frontend_tb_top.sv
`timescale 1ns/1ps
// Bench: vector table walk for the loading sequence, then directed tests.
module mreq_frontend_tb_top;
    localparam int DATA_W = 16;
    localparam int CMD_W  = 4;
    localparam int LEN_W  = 6;
    localparam int MIN_H  = 3;
    localparam int NVEC   = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr_n = 1'b1;
    logic              ld_en_n = 1'b1;
    logic [DATA_W-1:0] ld_data = '0;
    logic              busy_n = 1'b1;
    logic              wr_done = 1'b0;
    logic              rd_done = 1'b0;
    logic              tgt_abort = 1'b0;
    logic              tgt_disc = 1'b0;
    logic [3:0]        step_cnt_o;
    logic              req_full_n_o;
    logic              start_o;
    logic [CMD_W-1:0]  cmd_o;
    logic [LEN_W-1:0]  len_o;
    logic [DATA_W-1:0] addr_o;
    logic              abort_o;
    logic              ready_o;
    logic              bus_req_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mreq_frontend #(
        .DATA_W   (DATA_W),
        .CMD_W    (CMD_W),
        .LEN_W    (LEN_W),
        .MIN_HOLD (MIN_H)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_n        (clr_n),
        .ld_en_n      (ld_en_n),
        .ld_data      (ld_data),
        .busy_n       (busy_n),
        .wr_done      (wr_done),
        .rd_done      (rd_done),
        .tgt_abort    (tgt_abort),
        .tgt_disc     (tgt_disc),
        .step_cnt_o   (step_cnt_o),
        .req_full_n_o (req_full_n_o),
        .start_o      (start_o),
        .cmd_o        (cmd_o),
        .len_o        (len_o),
        .addr_o       (addr_o),
        .abort_o      (abort_o),
        .ready_o      (ready_o),
        .bus_req_o    (bus_req_o)
    );

    // vector: {ld_en_n, wr_done, rd_done, data[15:0], exp_step[3:0], exp_full_n, exp_start}
    localparam logic [24:0] VEC [NVEC] = '{
        {3'b100, 16'h0000, 4'd0, 1'b1, 1'b0},  // idle
        {3'b000, 16'h0002, 4'd1, 1'b1, 1'b0},  // write cmd
        {3'b100, 16'h0000, 4'd1, 1'b1, 1'b0},  // gap holds step
        {3'b000, 16'h0010, 4'd2, 1'b1, 1'b0},  // burst length
        {3'b000, 16'hA000, 4'd0, 1'b0, 1'b1},  // address -> full, start
        {3'b000, 16'h1234, 4'd0, 1'b0, 1'b0},  // R3 strobe ignored
        {3'b101, 16'h0000, 4'd0, 1'b0, 1'b0},  // R5 rd_done ignored on write
        {3'b110, 16'h0000, 4'd0, 1'b1, 1'b0},  // R5 wr_done frees
        {3'b000, 16'h0005, 4'd1, 1'b1, 1'b0},  // read cmd
        {3'b000, 16'h0004, 4'd2, 1'b1, 1'b0},  // burst length
        {3'b000, 16'hB000, 4'd0, 1'b0, 1'b1},  // address
        {3'b110, 16'h0000, 4'd0, 1'b0, 1'b0},  // R6 wr_done ignored on read
        {3'b101, 16'h0000, 4'd0, 1'b1, 1'b0}   // R6 rd_done frees
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic load(input logic [DATA_W-1:0] d);
        ld_en_n = 1'b0;
        ld_data = d;
        tick();
        ld_en_n = 1'b1;
    endtask

    initial begin
        #100000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // reset state (R12, R9)
        tick();
        tick();
        check("R12 step", 32'(step_cnt_o), 0);
        check("R12 full_n", 32'(req_full_n_o), 1);
        check("R12 start", 32'(start_o), 0);
        check("R12 abort", 32'(abort_o), 0);
        check("R12 bus_req", 32'(bus_req_o), 0);
        check("R9 ready in reset", 32'(ready_o), 0);
        rst_n = 1'b1;
        tick();
        check("R9 ready after reset", 32'(ready_o), 1);

        // vector walk (R2, R3, R4, R5, R6)
        for (int i = 0; i < NVEC; i++) begin
            ld_en_n = VEC[i][24];
            wr_done = VEC[i][23];
            rd_done = VEC[i][22];
            ld_data = VEC[i][21:6];
            tick();
            check($sformatf("R2 step vec%0d", i), 32'(step_cnt_o), 32'(VEC[i][5:2]));
            check($sformatf("R3 full_n vec%0d", i), 32'(req_full_n_o), 32'(VEC[i][1]));
            check($sformatf("R4 start vec%0d", i), 32'(start_o), 32'(VEC[i][0]));
        end
        ld_en_n = 1'b1;
        wr_done = 1'b0;
        rd_done = 1'b0;
        // R1 captured fields of the last request
        check("R1 cmd", 32'(cmd_o), 32'h5);
        check("R1 len", 32'(len_o), 32'h4);
        check("R1 addr", 32'(addr_o), 32'hB000);

        // R3 strobe during full keeps captured fields
        load(16'h0002);
        load(16'h0007);
        load(16'hC000);
        load(16'h0003);
        check("R3 cmd kept", 32'(cmd_o), 32'h2);
        check("R3 addr kept", 32'(addr_o), 32'hC000);
        check("R3 step kept", 32'(step_cnt_o), 0);

        // R7 abort frees, flag sticky until next start
        tgt_abort = 1'b1;
        tick();
        tgt_abort = 1'b0;
        check("R7 full_n", 32'(req_full_n_o), 1);
        check("R7 abort set", 32'(abort_o), 1);
        tgt_abort = 1'b1;
        tick();
        tgt_abort = 1'b0;
        check("R7 abort idle ignored full", 32'(req_full_n_o), 1);
        load(16'h0002);
        load(16'h0001);
        check("R7 abort held", 32'(abort_o), 1);
        load(16'hD000);
        check("R7 abort cleared at start", 32'(abort_o), 0);
        check("R7 start", 32'(start_o), 1);

        // R8/R9 async clear with a request outstanding
        clr_n = 1'b0;
        #1;
        check("R8 step", 32'(step_cnt_o), 0);
        check("R8 addr", 32'(addr_o), 0);
        check("R8 cmd", 32'(cmd_o), 0);
        check("R8 full_n", 32'(req_full_n_o), 1);
        check("R9 ready in clear", 32'(ready_o), 0);
        tick();
        tick();
        check("R9 ready held low", 32'(ready_o), 0);
        clr_n = 1'b1;
        tick();
        check("R9 ready after clear", 32'(ready_o), 1);
        load(16'h0003);
        load(16'h0002);
        clr_n = 1'b0;
        #1;
        check("R8 mid-sequence step", 32'(step_cnt_o), 0);
        check("R8 len", 32'(len_o), 0);
        tick();
        clr_n = 1'b1;
        tick();

        // R10/R11 busy hold released early -> minimum length
        busy_n = 1'b0;
        tick();
        check("R10 bus_req on hold", 32'(bus_req_o), 1);
        busy_n = 1'b1;
        tick();
        check("R11 hold cycle 2", 32'(bus_req_o), 1);
        tick();
        check("R11 hold cycle 3", 32'(bus_req_o), 1);
        tick();
        check("R11 hold released", 32'(bus_req_o), 0);

        // R11 disconnect ends hold and blocks rearm
        busy_n = 1'b0;
        tick();
        check("R10 hold again", 32'(bus_req_o), 1);
        tgt_disc = 1'b1;
        tick();
        tgt_disc = 1'b0;
        check("R11 disc ends hold", 32'(bus_req_o), 0);
        tick();
        tick();
        check("R11 no rearm while busy", 32'(bus_req_o), 0);
        busy_n = 1'b1;
        tick();
        busy_n = 1'b0;
        tick();
        check("R11 rearm after release", 32'(bus_req_o), 1);
        busy_n = 1'b1;
        for (int k = 0; k < 4; k++) tick();
        check("R11 final release", 32'(bus_req_o), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule